// File: doc/BRIEF.md
# PFC Supervisory State Sequencer

This block sequences the operating modes of a boost power-factor-correction controller. It receives six digital comparator flags: supply above the turn-on level, supply below the lockout level, feedback above the open-loop level, feedback below the under-voltage level, feedback above the over-voltage level, and soft-start complete. Every flag is retimed through a two-flop synchronizer. A four-state machine then selects one of four modes: off, standby, soft-start or run.

From the current mode and the synchronized flags the block drives:
- a one-hot mode indication;
- the gate enable;
- the selection between the low soft-start amplifier current and the high run-mode current;
- a fast duty-cut override;
- two clamps, which hold the current-loop compensation node high and discharge the voltage-loop compensation node.

Startup needs both the supply and the feedback to be healthy. The supply thresholds form a hysteresis pair. An output under-voltage in run mode shuts the block down as an open loop does, and sets a latch. While that latch is set, restart waits until the feedback has fallen below the open-loop level and risen above it again.

Top module: `pfc_seq`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the mode is off (`st_off_o`=1). `gate_en_o`, `ss_low_o`, `amp_hi_o`, `fast_cut_o`, `icomp_clamp_o` and `vcomp_dump_o` are 0 until the first clock edge.
- R2: The block leaves off for soft-start only when the supply is above turn-on, the feedback is above the open-loop level, and the supply is not below lockout. Either healthy flag alone keeps it in off.
- R3: A supply below lockout sends the block from any mode to off. It has priority over every other flag, and `gate_en_o` is 0 in off.
- R4: Once the block has started, the supply falling below turn-on has no effect while it stays above lockout.
- R5: In soft-start or run, feedback below the open-loop level moves the block to standby with the gate off. Standby returns to soft-start when the feedback recovers, unless the under-voltage latch is set.
- R6: In soft-start, `ss_low_o`=1 and `amp_hi_o`=0. The soft-start complete flag moves the block to run, where `ss_low_o`=0 and `amp_hi_o`=1.
- R7: Feedback below the under-voltage level moves the block from run to standby. The same flag is ignored in soft-start.
- R8: After an under-voltage shutdown, the block stays in standby while the feedback remains above the open-loop level. It restarts only after the feedback has gone below that level and come back above it.
- R9: Feedback above the over-voltage level sets `fast_cut_o` in soft-start or run without changing the mode. `fast_cut_o` stays 0 in off and in standby, and also when a shutdown flag is active in the same cycle.
- R10: `icomp_clamp_o` and `vcomp_dump_o` are 1 in off and standby and 0 in soft-start and run.
- R11: An input flag change takes effect on the mode outputs at the third rising clock edge after it is applied, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_uvlo_i | input | 1 | Supply below lockout level |
| fb_ok_i | input | 1 | Feedback above open-loop level |
| fb_uv_i | input | 1 | Feedback below under-voltage level |
| fb_ov_i | input | 1 | Feedback above over-voltage level |
| ss_done_i | input | 1 | Soft-start end reached |
| st_off_o | output | 1 | Mode is off |
| st_stby_o | output | 1 | Mode is standby (open loop or under-voltage) |
| st_soft_o | output | 1 | Mode is soft-start |
| st_run_o | output | 1 | Mode is run |
| gate_en_o | output | 1 | Gate driver enable |
| ss_low_o | output | 1 | Select low soft-start amplifier current |
| amp_hi_o | output | 1 | Select high run-mode amplifier current |
| fast_cut_o | output | 1 | Fast duty-reduction override |
| icomp_clamp_o | output | 1 | Tie current-loop compensation node high |
| vcomp_dump_o | output | 1 | Discharge voltage-loop compensation node |

## Verification
The startup gate is tried with each healthy flag alone and then with both together. This separates a correct AND from an OR or from a single-flag check.

Shutdown is provoked three ways: lockout, open loop and under-voltage. The under-voltage case is run both in run mode and in soft-start, which shows that the flag is decoded per mode. The re-arm after an under-voltage shutdown is checked with feedback held high and then with feedback cycled through the open-loop level, which exposes a missing latch.

Over-voltage is applied alone in run mode, in standby, and together with an open loop. These cases separate an override that leaves the mode unchanged from one that ignores priority. A step is also sampled two and three edges after it is applied, which pins the synchronizer depth.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STBY = 2'd1,
    MODE_SOFT = 2'd2,
    MODE_RUN  = 2'd3
  } mode_e;

  localparam int unsigned FL_VON  = 0;
  localparam int unsigned FL_UVLO = 1;
  localparam int unsigned FL_FBOK = 2;
  localparam int unsigned FL_FBUV = 3;
  localparam int unsigned FL_FBOV = 4;
  localparam int unsigned FL_SSDN = 5;
  localparam int unsigned NFLAG   = 6;

  function automatic logic mode_active(mode_e m);
    return (m == MODE_SOFT) || (m == MODE_RUN);
  endfunction
endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= rst_val_i;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= rst_val_i;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
  import pfc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  von_i,
  input  logic  uvlo_i,
  input  logic  fbok_i,
  input  logic  fbuv_i,
  input  logic  ssdn_i,
  output mode_e mode_q_o,
  output mode_e mode_d_o
);
  mode_e mode_q, mode_d;
  logic  uv_lock_q, uv_lock_d;

  always_comb begin
    mode_d    = mode_q;
    uv_lock_d = uv_lock_q;
    if (uvlo_i) begin
      // lockout wins over everything
      mode_d    = MODE_OFF;
      uv_lock_d = 1'b0;
    end else begin
      if (!fbok_i) uv_lock_d = 1'b0;
      unique case (mode_q)
        MODE_OFF: begin
          if (von_i && fbok_i) mode_d = MODE_SOFT;
        end
        MODE_STBY: begin
          if (fbok_i && !uv_lock_q) mode_d = MODE_SOFT;
        end
        MODE_SOFT: begin
          if (!fbok_i)     mode_d = MODE_STBY;
          else if (ssdn_i) mode_d = MODE_RUN;
        end
        MODE_RUN: begin
          if (!fbok_i) begin
            mode_d = MODE_STBY;
          end else if (fbuv_i) begin
            mode_d    = MODE_STBY;
            uv_lock_d = 1'b1;
          end
        end
        default: mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      uv_lock_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      uv_lock_q <= uv_lock_d;
    end
  end

  assign mode_q_o = mode_q;
  assign mode_d_o = mode_d;
endmodule

// File: rtl/pfc_out_stage.sv
module pfc_out_stage
  import pfc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_q_i,
  input  mode_e mode_d_i,
  input  logic  ov_i,
  input  logic  uvlo_i,
  output logic  st_off_o,
  output logic  st_stby_o,
  output logic  st_soft_o,
  output logic  st_run_o,
  output logic  gate_en_o,
  output logic  ss_low_o,
  output logic  amp_hi_o,
  output logic  fast_cut_o,
  output logic  icomp_clamp_o,
  output logic  vcomp_dump_o
);
  logic ss_low_q, amp_hi_q, fast_cut_q, clamp_q, dump_q;

  assign st_off_o  = (mode_q_i == MODE_OFF);
  assign st_stby_o = (mode_q_i == MODE_STBY);
  assign st_soft_o = (mode_q_i == MODE_SOFT);
  assign st_run_o  = (mode_q_i == MODE_RUN);
  // gate also cut directly by the synced lockout flag
  assign gate_en_o = mode_active(mode_q_i) && !uvlo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_low_q   <= 1'b0;
      amp_hi_q   <= 1'b0;
      fast_cut_q <= 1'b0;
      clamp_q    <= 1'b0;
      dump_q     <= 1'b0;
    end else begin
      ss_low_q   <= (mode_d_i == MODE_SOFT);
      amp_hi_q   <= (mode_d_i == MODE_RUN);
      fast_cut_q <= mode_active(mode_d_i) && ov_i;
      clamp_q    <= !mode_active(mode_d_i);
      dump_q     <= !mode_active(mode_d_i);
    end
  end

  assign ss_low_o      = ss_low_q;
  assign amp_hi_o      = amp_hi_q;
  assign fast_cut_o    = fast_cut_q;
  assign icomp_clamp_o = clamp_q;
  assign vcomp_dump_o  = dump_q;
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_on_i,
  input  logic vcc_uvlo_i,
  input  logic fb_ok_i,
  input  logic fb_uv_i,
  input  logic fb_ov_i,
  input  logic ss_done_i,
  output logic st_off_o,
  output logic st_stby_o,
  output logic st_soft_o,
  output logic st_run_o,
  output logic gate_en_o,
  output logic ss_low_o,
  output logic amp_hi_o,
  output logic fast_cut_o,
  output logic icomp_clamp_o,
  output logic vcomp_dump_o
);
  logic [NFLAG-1:0] flags_raw, flags_s, flags_rst;
  logic  uvlo_s;
  mode_e mode_q, mode_d;

  always_comb begin
    flags_raw          = '0;
    flags_raw[FL_VON]  = vcc_on_i;
    flags_raw[FL_UVLO] = vcc_uvlo_i;
    flags_raw[FL_FBOK] = fb_ok_i;
    flags_raw[FL_FBUV] = fb_uv_i;
    flags_raw[FL_FBOV] = fb_ov_i;
    flags_raw[FL_SSDN] = ss_done_i;
    // reset to the unpowered picture: lockout active, feedback low
    flags_rst          = '0;
    flags_rst[FL_UVLO] = 1'b1;
    flags_rst[FL_FBUV] = 1'b1;
  end

  pfc_flag_sync #(
    .WIDTH (NFLAG),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (flags_raw),
    .rst_val_i(flags_rst),
    .q_o      (flags_s)
  );

  assign uvlo_s = flags_s[FL_UVLO];

  pfc_mode_fsm fsm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .von_i   (flags_s[FL_VON]),
    .uvlo_i  (uvlo_s),
    .fbok_i  (flags_s[FL_FBOK]),
    .fbuv_i  (flags_s[FL_FBUV]),
    .ssdn_i  (flags_s[FL_SSDN]),
    .mode_q_o(mode_q),
    .mode_d_o(mode_d)
  );

  pfc_out_stage out_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_q_i     (mode_q),
    .mode_d_i     (mode_d),
    .ov_i         (flags_s[FL_FBOV]),
    .uvlo_i       (uvlo_s),
    .st_off_o     (st_off_o),
    .st_stby_o    (st_stby_o),
    .st_soft_o    (st_soft_o),
    .st_run_o     (st_run_o),
    .gate_en_o    (gate_en_o),
    .ss_low_o     (ss_low_o),
    .amp_hi_o     (amp_hi_o),
    .fast_cut_o   (fast_cut_o),
    .icomp_clamp_o(icomp_clamp_o),
    .vcomp_dump_o (vcomp_dump_o)
  );
endmodule

// File: rtl/pfc_seq_chk.sv
module pfc_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uvlo_s,
  input logic st_off_o,
  input logic st_stby_o,
  input logic st_soft_o,
  input logic st_run_o,
  input logic gate_en_o,
  input logic ss_low_o,
  input logic amp_hi_o,
  input logic fast_cut_o,
  input logic icomp_clamp_o
);
  p_onehot_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({st_off_o, st_stby_o, st_soft_o, st_run_o}));

  p_uvlo_to_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_s |=> st_off_o);

  p_uvlo_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_s |-> !gate_en_o);

  p_no_skip_soft_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_off_o |=> !st_run_o);

  p_ss_low_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_low_o |-> st_soft_o && !amp_hi_o);

  p_fast_cut_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_cut_o |-> (st_soft_o || st_run_o));

  p_clamp_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icomp_clamp_o |-> (st_off_o || st_stby_o) && !gate_en_o);
endmodule

bind pfc_seq pfc_seq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .uvlo_s       (uvlo_s),
  .st_off_o     (st_off_o),
  .st_stby_o    (st_stby_o),
  .st_soft_o    (st_soft_o),
  .st_run_o     (st_run_o),
  .gate_en_o    (gate_en_o),
  .ss_low_o     (ss_low_o),
  .amp_hi_o     (amp_hi_o),
  .fast_cut_o   (fast_cut_o),
  .icomp_clamp_o(icomp_clamp_o)
);

// File: tb/pfc_seq_tb.sv
module pfc_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic von, uvlo, fbok, fbuv, fbov, ssdn;
  logic st_off, st_stby, st_soft, st_run, gate_en, ss_low, amp_hi, fast_cut, iclamp, vdump;
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pfc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .vcc_on_i(von), .vcc_uvlo_i(uvlo), .fb_ok_i(fbok), .fb_uv_i(fbuv),
    .fb_ov_i(fbov), .ss_done_i(ssdn),
    .st_off_o(st_off), .st_stby_o(st_stby), .st_soft_o(st_soft), .st_run_o(st_run),
    .gate_en_o(gate_en), .ss_low_o(ss_low), .amp_hi_o(amp_hi), .fast_cut_o(fast_cut),
    .icomp_clamp_o(iclamp), .vcomp_dump_o(vdump)
  );

  // mode code: 1=off 2=stby 4=soft 8=run
  task automatic chk_mode(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {st_run, st_soft, st_stby, st_off};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode: got %b exp %b", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", tag, act, exp);
    end
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk);
    uvlo = 1; von = 0; fbok = 0; fbuv = 0; fbov = 0; ssdn = 0;
    settle();
    uvlo = 0; von = 1; fbok = 1;
    settle();
  endtask

  task automatic to_run();
    power_up();
    ssdn = 1;
    settle();
    ssdn = 0;
    settle(1);
  endtask

  task automatic t_reset();
    von = 0; uvlo = 1; fbok = 0; fbuv = 1; fbov = 0; ssdn = 0;
    #3;
    chk_mode(4'b0001, "R1 reset");
    chk_bit(gate_en, 0, "R1 gate at reset");
    chk_bit(ss_low | amp_hi | fast_cut | iclamp | vdump, 0, "R1 registered outs at reset");
    #20 rst_n = 1'b1;
  endtask

  task automatic t_start_gating();
    @(negedge clk);
    uvlo = 0; von = 1; fbok = 0; fbuv = 0;
    settle();
    chk_mode(4'b0001, "R2 supply only");
    von = 0; fbok = 1;
    settle();
    chk_mode(4'b0001, "R2 feedback only");
    von = 1;
    settle();
    chk_mode(4'b0100, "R2 both healthy");
    chk_bit(gate_en, 1, "R2 gate in soft");
    chk_bit(iclamp, 1'b1 === 1'b0, "R10 clamp off in soft");
  endtask

  task automatic t_soft_run();
    power_up();
    chk_bit(ss_low, 1, "R6 ss_low in soft");
    chk_bit(amp_hi, 0, "R6 amp_hi in soft");
    ssdn = 1;
    settle();
    chk_mode(4'b1000, "R6 soft to run");
    chk_bit(ss_low, 0, "R6 ss_low in run");
    chk_bit(amp_hi, 1, "R6 amp_hi in run");
    chk_bit(vdump, 0, "R10 dump off in run");
    ssdn = 0;
  endtask

  task automatic t_hysteresis();
    to_run();
    von = 0;
    settle();
    chk_mode(4'b1000, "R4 below turn-on above lockout");
    chk_bit(gate_en, 1, "R4 gate kept");
    uvlo = 1;
    settle();
    chk_mode(4'b0001, "R3 lockout from run");
    chk_bit(gate_en, 0, "R3 gate off");
    chk_bit(iclamp, 1, "R10 clamp in off");
    chk_bit(vdump, 1, "R10 dump in off");
  endtask

  task automatic t_open_loop();
    to_run();
    fbok = 0;
    settle();
    chk_mode(4'b0010, "R5 open loop from run");
    chk_bit(gate_en, 0, "R5 gate in standby");
    chk_bit(iclamp, 1, "R10 clamp in standby");
    fbok = 1;
    settle();
    chk_mode(4'b0100, "R5 recover to soft");
  endtask

  task automatic t_uv();
    to_run();
    fbuv = 1;
    settle();
    chk_mode(4'b0010, "R7 uv shutdown from run");
    fbuv = 0;
    settle(8);
    chk_mode(4'b0010, "R8 held while feedback stays up");
    fbok = 0;
    settle();
    fbok = 1;
    settle();
    chk_mode(4'b0100, "R8 restart after re-arm");
    fbuv = 1;
    settle();
    chk_mode(4'b0100, "R7 uv ignored in soft");
    fbuv = 0;
  endtask

  task automatic t_ov();
    to_run();
    fbov = 1;
    settle();
    chk_mode(4'b1000, "R9 ov keeps run");
    chk_bit(fast_cut, 1, "R9 fast cut in run");
    fbov = 0;
    settle();
    chk_bit(fast_cut, 0, "R9 fast cut released");
    fbok = 0;
    settle();
    fbov = 1;
    settle();
    chk_bit(fast_cut, 0, "R9 no cut in standby");
    fbov = 0;
  endtask

  task automatic t_priority();
    to_run();
    fbov = 1; fbok = 0;
    settle();
    chk_mode(4'b0010, "R9 shutdown beats ov");
    chk_bit(fast_cut, 0, "R9 cut masked by shutdown");
    fbok = 1; fbov = 0;
    settle();
    uvlo = 1; fbok = 0; fbov = 1; ssdn = 1;
    settle();
    chk_mode(4'b0001, "R3 lockout beats all");
    chk_bit(fast_cut, 0, "R3 cut off in lockout");
    fbov = 0; ssdn = 0;
  endtask

  task automatic t_latency();
    power_up();
    chk_mode(4'b0100, "R11 start in soft");
    ssdn = 1;
    settle(2);
    chk_mode(4'b0100, "R11 unchanged after two edges");
    settle(1);
    chk_mode(4'b1000, "R11 changed at third edge");
    ssdn = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles exp completion", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start_gating();
    t_soft_run();
    t_hysteresis();
    t_open_loop();
    t_uv();
    t_ov();
    t_priority();
    t_latency();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule